// File: doc/BRIEF.md
# Second-Order Ternary Sigma-Delta Modulator

This block turns a stream of signed multi-bit samples into a stream of three-level symbols (-1, 0, +1). A typical source is an interpolated impulse response that is to become the tap set of a multiplier-free filter. The loop has two integrators. Each integrator subtracts the fed-back symbol, scaled to full scale T. A ternary quantizer then decides the next symbol from the updated second integrator. As a result, the signal reaches the output with a one-sample delay, and the quantization error is shaped by (1 - z^-1)^2. The block is meant to run at an oversampling ratio of about 32.

Each sample accepted with `in_valid` produces exactly one symbol on the following clock. The symbol is the quantized value of the loop after that sample. On cycles without a sample the loop state does not move.

The quantizer is a three-state machine. Its states are SYM_ZERO (code 00), SYM_POS (code 01) and SYM_NEG (code 11). On each accepted sample, every state may move to any of the three states:
- It moves to SYM_POS when the updated second integrator is above T/2.
- It moves to SYM_NEG when that integrator is below -T/2.
- It moves to SYM_ZERO otherwise.

With no sample, every state stays where it is. Reset enters SYM_ZERO.

Top module: `tsdm_mod`

## Requirements
- R1: `out_valid` is high in the clock after each cycle with `in_valid` high, and low in the clock after each cycle with `in_valid` low.
- R2: `out_sym` is a 2-bit two's-complement symbol: 01 means +1, 00 means 0, 11 means -1. The code 10 never appears.
- R3: The new symbol is +1 if the updated second integrator is strictly greater than T/2. It is -1 if that integrator is strictly less than -T/2. Otherwise it is 0, and this includes values of exactly ±T/2. T = 2^FS_LOG2, which is 16384 by default.
- R4: On an accepted sample x, the first integrator becomes a1 + x - F. Here F is T times the symbol currently on `out_sym`, which is 0 after reset.
- R5: On the same sample, the second integrator becomes a2 + a1' - F, where a1' is the updated first integrator.
- R6: Each integrator result is clamped to the signed IW-bit range [-2^(IW-1), 2^(IW-1)-1] instead of wrapping. IW is 20 by default.
- R7: While `in_valid` is low, both integrators and `out_sym` keep their values.
- R8: Reset clears both integrators, sets `out_sym` to 00 and drives `out_valid` low.
- R9: For a constant input x with |x| ≤ T/2, the sum of the symbols over N samples stays within ±4 of N·x/T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | DW (16) | Signed input sample |
| out_valid | output | 1 | A new symbol is presented |
| out_sym | output | 2 | Ternary symbol, two's complement |

## Verification
The bench builds each loop input to land exactly on, and one step past, the ±T/2 thresholds. A quantizer that used ≥ in place of > would emit ±1 where 0 is required.

An input of twice full scale is held long enough to push both integrators into their limits and then pulled back the other way. An accumulator that wrapped would flip sign and diverge from the clamped model. After that, a reset followed by an impulse shows whether stale integrator state survives reset.

Random samples with random gaps in `in_valid` check that idle cycles freeze the loop and that the feedback is taken from the symbol actually on the output. A long DC run checks that the mean of the symbols tracks the input, which a sign error in either feedback path would destroy.

// File: rtl/tsdm_pkg.sv
package tsdm_pkg;
    // Ternary symbol, two's complement on two bits
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b11
    } sym_e;
endpackage

// File: rtl/tsdm_integ.sv
module tsdm_integ #(
    parameter int IW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [IW-1:0] add_term,
    input  logic signed [IW-1:0] fb,
    output logic signed [IW-1:0] acc_d,
    output logic signed [IW-1:0] acc_q
);
    localparam int EW = IW + 2;
    localparam logic signed [EW-1:0] HI = {3'b000, {(IW-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = {3'b111, {(IW-1){1'b0}}};

    logic signed [EW-1:0] sum;

    // Widened sum, then clamp to the IW-bit signed range
    always_comb begin
        sum = {{2{acc_q[IW-1]}}, acc_q}
            + {{2{add_term[IW-1]}}, add_term}
            - {{2{fb[IW-1]}}, fb};
        if (sum > HI)
            acc_d = HI[IW-1:0];
        else if (sum < LO)
            acc_d = LO[IW-1:0];
        else
            acc_d = sum[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_d;
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q)); // R7

    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc_q > 0 && add_term >= fb) |=> (acc_q >= $past(acc_q))); // R6

    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc_q < 0 && add_term <= fb) |=> (acc_q <= $past(acc_q))); // R6
endmodule

// File: rtl/tsdm_quant.sv
module tsdm_quant
    import tsdm_pkg::*;
#(
    parameter int IW      = 20,
    parameter int FS_LOG2 = 14
) (
    input  logic signed [IW-1:0] level,
    output sym_e                 sym
);
    localparam logic signed [IW-1:0] HALF = IW'(2 ** (FS_LOG2 - 1));

    always_comb begin
        if (level > HALF)
            sym = SYM_POS;
        else if (level < -HALF)
            sym = SYM_NEG;
        else
            sym = SYM_ZERO;
    end
endmodule

// File: rtl/tsdm_mod.sv
module tsdm_mod
    import tsdm_pkg::*;
#(
    parameter int DW      = 16,
    parameter int GUARD   = 4,
    parameter int FS_LOG2 = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 out_valid,
    output logic [1:0]           out_sym
);
    localparam int IW = DW + GUARD;
    localparam logic signed [IW-1:0] FS_V = IW'(2 ** FS_LOG2);
    localparam logic signed [IW-1:0] HALF = IW'(2 ** (FS_LOG2 - 1));

    sym_e                 sym_q;
    sym_e                 sym_nx;
    sym_e                 q_sym;
    logic signed [IW-1:0] fb;
    logic signed [IW-1:0] x_ext;
    logic signed [IW-1:0] i1_d, i1_q;
    logic signed [IW-1:0] i2_d, i2_q;
    logic                 vld_q;

    assign x_ext = {{GUARD{in_sample[DW-1]}}, in_sample};

    // First integrator: sample minus feedback
    tsdm_integ #(.IW(IW)) u_int1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_valid),
        .add_term (x_ext),
        .fb       (fb),
        .acc_d    (i1_d),
        .acc_q    (i1_q)
    );

    // Second integrator: updated first integrator minus feedback
    tsdm_integ #(.IW(IW)) u_int2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_valid),
        .add_term (i1_d),
        .fb       (fb),
        .acc_d    (i2_d),
        .acc_q    (i2_q)
    );

    tsdm_quant #(.IW(IW), .FS_LOG2(FS_LOG2)) u_quant (
        .level (i2_d),
        .sym   (q_sym)
    );

    // State register of the quantizer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= SYM_ZERO;
            vld_q <= 1'b0;
        end else begin
            sym_q <= sym_nx;
            vld_q <= in_valid;
        end
    end

    // Next state and feedback from the current state
    always_comb begin
        sym_nx = in_valid ? q_sym : sym_q;
        unique case (sym_q)
            SYM_POS:  fb = FS_V;
            SYM_NEG:  fb = -FS_V;
            default:  fb = '0;
        endcase
    end

    assign out_valid = vld_q;
    assign out_sym   = sym_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sym != 2'b10); // R2
    AST_POS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_q == SYM_POS) |-> (i2_q > HALF)); // R3
    AST_NEG_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_q == SYM_NEG) |-> (i2_q < -HALF)); // R3
    AST_ZERO_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_q == SYM_ZERO) |-> (i2_q <= HALF && i2_q >= -HALF)); // R3
    AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sym)); // R7
endmodule

// File: tb/tb_tsdm_mod.sv
module tb_tsdm_mod;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int IW = 20;
    localparam longint T = 16384;
    localparam longint IMAX = (64'sd1 <<< (IW - 1)) - 1;
    localparam longint IMIN = -(64'sd1 <<< (IW - 1));

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic                 out_valid;
    logic [1:0]           out_sym;

    int n_cmp = 0;
    int n_bad = 0;

    longint m_i1, m_i2;
    int     m_sym;

    tsdm_mod dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_sym   (out_sym)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint clampv(longint v);
        if (v > IMAX) return IMAX;
        if (v < IMIN) return IMIN;
        return v;
    endfunction

    function automatic int quant(longint v);
        if (v > T / 2) return 1;
        if (v < -(T / 2)) return -1;
        return 0;
    endfunction

    function automatic logic [1:0] enc(int s);
        return (s == 1) ? 2'b01 : (s == -1) ? 2'b11 : 2'b00;
    endfunction

    function automatic int dec(logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_i1 = 0;
        m_i2 = 0;
        m_sym = 0;
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic step(input int x, input logic v, input string req);
        longint f;
        in_valid = v;
        in_sample = DW'(x);
        if (v) begin
            f = longint'(m_sym) * T;
            m_i1 = clampv(m_i1 + x - f);
            m_i2 = clampv(m_i2 + m_i1 - f);
            m_sym = quant(m_i2);
        end
        @(negedge clk);
        check({req, " valid"}, {31'b0, out_valid}, {31'b0, v});
        check({req, " sym"}, {30'b0, out_sym}, {30'b0, enc(m_sym)});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int acc;
        void'($urandom(32'd20240611));
        do_reset();
        // R8: reset state
        check("R8 reset valid", {31'b0, out_valid}, 32'd0);
        check("R8 reset sym", {30'b0, out_sym}, 32'd0);

        // R3: threshold corners, each from a fresh reset
        do_reset(); step(8192, 1'b1, "R3 at +T/2 -> 0");
        do_reset(); step(8193, 1'b1, "R3 above +T/2 -> +1");
        do_reset(); step(-8192, 1'b1, "R3 at -T/2 -> 0");
        do_reset(); step(-8193, 1'b1, "R3 below -T/2 -> -1");

        // R4/R5: impulse response, then idle gaps (R7, R1)
        do_reset();
        step(16384, 1'b1, "R4 impulse");
        for (int k = 0; k < 12; k++) step(0, 1'b1, "R5 impulse tail");
        for (int k = 0; k < 4; k++) step(12345, 1'b0, "R7 idle hold");
        step(0, 1'b1, "R1 resume");

        // R6: drive far past full scale both ways
        for (int k = 0; k < 80; k++) step(32767, 1'b1, "R6 saturate high");
        for (int k = 0; k < 160; k++) step(-32768, 1'b1, "R6 saturate low");

        // R8: reset clears integrators, impulse repeats
        do_reset();
        step(16384, 1'b1, "R8 post-reset impulse");
        for (int k = 0; k < 4; k++) step(0, 1'b1, "R8 post-reset tail");

        // R9: DC mean tracking
        do_reset();
        acc = 0;
        for (int k = 0; k < 1024; k++) begin
            step(4096, 1'b1, "R9 dc run");
            acc += dec(out_sym);
        end
        n_cmp++;
        if (acc < 252 || acc > 260) begin
            n_bad++;
            $display("FAIL R9 symbol sum actual=%0d expected=256+-4", acc);
        end

        // R2/R4/R5/R7: random in-range samples with gaps
        do_reset();
        for (int k = 0; k < 3000; k++) begin
            int x;
            logic v;
            x = int'($urandom_range(0, 16384)) - 8192;
            v = ($urandom_range(0, 3) != 0);
            step(x, v, "R4 random");
            check("R2 legal code", {31'b0, out_sym == 2'b10}, 32'd0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule